// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns three external pin levels into interrupt requests. Each pin passes through a synchroniser, and an edge detector then compares each synchronised sample with the one from the cycle before. The two lower inputs each have a two-bit sense field in a control register. That field selects one of three triggers: a low level, a falling edge or a rising edge. The highest input reacts only to edges, and a single polarity bit chooses which edge. In an edge mode, a detected edge sets a sticky flag. That flag is cleared when the interrupt vector is acknowledged or when software writes a one to it. In low-level mode no flag is kept: the request simply follows the pin for as long as the pin stays low.

The pad value is sampled whether or not the pin is driven as an output. Software can therefore raise an interrupt by driving its own pin. Each request is gated by its own enable bit before it leaves the block. The upper four control bits hold a sleep enable and a three-bit sleep mode. Here they are stored and read back, and they have no effect on detection. Bus decoding around these fields and the vector prioritiser sit outside the block.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the control register, polarity bit, enables, flags and requests are all zero.
- R2: A control write stores all 8 bits and reads back unchanged. Bits 7:4 (sleep enable and sleep mode) do not change detection.
- R3: Input i<2 uses control bits [2i+1:2i]. Code 00 selects low level: `irq_o[i]` equals its enable AND the inverted synchronised pin, and no flag is set.
- R4: Code 10 sets `flags_o[i]` on a 1-to-0 pin transition. The flag then stays set after the pin returns high, until it is cleared.
- R5: Code 11 sets `flags_o[i]` on a 0-to-1 transition, and the flag is sticky in the same way.
- R6: Code 01 (any change) is reserved and never sets a flag.
- R7: Input 2 is edge-only. Polarity bit 0 selects the falling edge and 1 selects the rising edge.
- R8: In an edge mode, `irq_o[i]` is the enable AND the flag. A disabled input still sets its flag but raises no request.
- R9: A flag-clear write clears each flag whose data bit is 1. Flags whose data bit is 0 are left alone.
- R10: A one-cycle pulse on `ack_i[i]` clears `flags_o[i]`.
- R11: When a flag set and a clear fall in the same cycle, the set wins.
- R12: A pin change made before clock edge k shows in a flag after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Pad values, sampled regardless of pin direction |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: [3:0] sense fields, [7:4] sleep bits |
| ctrl_rdata | output | 8 | Control register contents |
| pol_we | input | 1 | Input 2 polarity write strobe |
| pol_wdata | input | 1 | Input 2 polarity: 0 falling, 1 rising |
| pol_o | output | 1 | Stored input 2 polarity |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | Per-input enable data |
| en_o | output | 3 | Stored enables |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for flags |
| flag_clr_wdata | input | 3 | Flags to clear |
| ack_i | input | 3 | Vector acknowledge, clears the matching flag |
| flags_o | output | 3 | Sticky edge flags |
| irq_o | output | 3 | Gated interrupt requests |

## Verification
The bench builds the block with its defaults: two level-capable inputs, one edge-only input and a two-stage synchroniser. This is small enough to sweep every input against every sense code, both enable values and both edge directions, and to write all 256 control values. A two-stage synchroniser keeps the latency short and fixed, so each sweep case can sample the flag exactly one cycle before and at the edge where it should appear. Directed sequences then cover partial write-one-to-clear and a set and clear landing in the same cycle.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Whether a sense selection turns the detected transitions into a flag event
  function automatic logic sense_fires(sense_e mode, logic rise, logic fall);
    case (mode)
      SENSE_FALL: return fall;
      SENSE_RISE: return rise;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic sense_is_level(sense_e mode);
    return mode == SENSE_LOW;
  endfunction

  // Edge-only input: the polarity bit picks the edge
  function automatic sense_e edge_only_mode(logic pol);
    return pol ? SENSE_RISE : SENSE_FALL;
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  // Idle level of an external pin is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/eis_edge.sv
module eis_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/eis_flag_cell.sv
module eis_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // A new event takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter  int LVL_INPUTS  = 2,
  parameter  int SLEEP_BITS  = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int N_IN        = LVL_INPUTS + 1,
  localparam int CTRL_W      = 2 * LVL_INPUTS + SLEEP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pin_i,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              pol_we,
  input  logic              pol_wdata,
  output logic              pol_o,
  input  logic              en_we,
  input  logic [N_IN-1:0]   en_wdata,
  output logic [N_IN-1:0]   en_o,
  input  logic              flag_clr_we,
  input  logic [N_IN-1:0]   flag_clr_wdata,
  input  logic [N_IN-1:0]   ack_i,
  output logic [N_IN-1:0]   flags_o,
  output logic [N_IN-1:0]   irq_o
);
  import eis_pkg::*;

  localparam int FIELD_W = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic              pol_q;
  logic [N_IN-1:0]   en_q;

  // Named internal events, visible to the bound checker
  logic [N_IN-1:0] sync_lvl;
  logic [N_IN-1:0] rise_ev;
  logic [N_IN-1:0] fall_ev;
  logic [N_IN-1:0] set_ev;
  logic [N_IN-1:0] clr_ev;
  logic [N_IN-1:0] flag_q;
  sense_e          mode_w [N_IN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pol_q  <= 1'b0;
      en_q   <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (pol_we)  pol_q  <= pol_wdata;
      if (en_we)   en_q   <= en_wdata;
    end
  end

  eis_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (sync_lvl)
  );

  eis_edge #(.W(N_IN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sync_lvl),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    if (i < LVL_INPUTS) begin : g_lvl
      assign mode_w[i] = sense_e'(ctrl_q[FIELD_W*i +: FIELD_W]);
    end else begin : g_edge_only
      assign mode_w[i] = edge_only_mode(pol_q);
    end

    assign set_ev[i] = sense_fires(mode_w[i], rise_ev[i], fall_ev[i]);
    assign clr_ev[i] = ack_i[i] | (flag_clr_we & flag_clr_wdata[i]);

    eis_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_ev[i]),
      .clr_i  (clr_ev[i]),
      .flag_o (flag_q[i])
    );

    assign irq_o[i] = en_q[i] &
                      (sense_is_level(mode_w[i]) ? ~sync_lvl[i] : flag_q[i]);
  end

  assign ctrl_rdata = ctrl_q;
  assign pol_o      = pol_q;
  assign en_o       = en_q;
  assign flags_o    = flag_q;

endmodule

// File: rtl/eis_chk.sv
module eis_chk #(
  parameter  int LVL_INPUTS = 2,
  parameter  int SLEEP_BITS = 4,
  localparam int N_IN       = LVL_INPUTS + 1,
  localparam int CTRL_W     = 2 * LVL_INPUTS + SLEEP_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_rdata,
  input logic [N_IN-1:0]   en_o,
  input logic              flag_clr_we,
  input logic [N_IN-1:0]   flag_clr_wdata,
  input logic [N_IN-1:0]   ack_i,
  input logic [N_IN-1:0]   flags_o,
  input logic [N_IN-1:0]   irq_o,
  input logic [N_IN-1:0]   set_ev,
  input logic [N_IN-1:0]   sync_lvl
);

  for (genvar k = 0; k < N_IN; k++) begin : g_k
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[k] && !ack_i[k] && !(flag_clr_we && flag_clr_wdata[k]) |=> flags_o[k]);

    // R5
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[k]) |-> $past(set_ev[k]));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[k] |=> flags_o[k]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_o[k] |-> !irq_o[k]);

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i[k] && !set_ev[k] |=> !flags_o[k]);

    if (k < LVL_INPUTS) begin : g_lvl
      // R6
      any_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[2*k +: 2] == 2'b01 && !flags_o[k] |=> !flags_o[k]);

      // R3
      level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[2*k +: 2] == 2'b00 && !flags_o[k] |=> !flags_o[k]);

      // R3
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[2*k +: 2] == 2'b00 && en_o[k] |-> irq_o[k] == !sync_lvl[k]);
    end
  end

endmodule

bind ext_irq_sense eis_chk #(
  .LVL_INPUTS (LVL_INPUTS),
  .SLEEP_BITS (SLEEP_BITS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_rdata     (ctrl_rdata),
  .en_o           (en_o),
  .flag_clr_we    (flag_clr_we),
  .flag_clr_wdata (flag_clr_wdata),
  .ack_i          (ack_i),
  .flags_o        (flags_o),
  .irq_o          (irq_o),
  .set_ev         (set_ev),
  .sync_lvl       (sync_lvl)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin_i = 3'b111;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       pol_we = 1'b0;
  logic       pol_wdata = 1'b0;
  logic       pol_o;
  logic       en_we = 1'b0;
  logic [2:0] en_wdata = '0;
  logic [2:0] en_o;
  logic       flag_clr_we = 1'b0;
  logic [2:0] flag_clr_wdata = '0;
  logic [2:0] ack_i = '0;
  logic [2:0] flags_o;
  logic [2:0] irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata), .pol_o(pol_o),
    .en_we(en_we), .en_wdata(en_wdata), .en_o(en_o),
    .flag_clr_we(flag_clr_we), .flag_clr_wdata(flag_clr_wdata),
    .ack_i(ack_i), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // Bench model of the sense codes: 10 falling, 11 rising, others no flag
  function automatic logic model_fires(logic [1:0] code, logic is_fall);
    return (code == 2'b10 && is_fall) || (code == 2'b11 && !is_fall);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_pol(logic v);
    @(negedge clk); pol_we = 1'b1; pol_wdata = v;
    @(negedge clk); pol_we = 1'b0;
  endtask

  task automatic wr_en(logic [2:0] v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic w1c(logic [2:0] v);
    @(negedge clk); flag_clr_we = 1'b1; flag_clr_wdata = v;
    @(negedge clk); flag_clr_we = 1'b0; flag_clr_wdata = '0;
  endtask

  task automatic run_case(int i, logic [1:0] code, logic en, logic is_fall);
    string tag;
    logic  exp_f, exp_f2, exp_irq, lvl;
    lvl = (i < 2) && (code == 2'b00);
    tag = (i == 2) ? "R7" : (code == 2'b00) ? "R3" : (code == 2'b01) ? "R6" :
          (code == 2'b10) ? "R4" : "R5";
    pin_i = 3'b111;
    if (i < 2) wr_ctrl(8'(code) << (2 * i));
    else begin wr_ctrl(8'h00); wr_pol(code[0]); end
    wr_en(3'(en) << i);
    if (!is_fall) pin_i[i] = 1'b0;
    cyc(5);
    w1c(3'b111);
    pin_i[i] = is_fall ? 1'b0 : 1'b1;
    cyc(2);
    check("R12 flag before third edge", 32'(flags_o[i]), 32'd0);
    cyc(1);
    exp_f   = model_fires(code, is_fall);
    exp_irq = lvl ? (en & is_fall) : (en & exp_f);
    check({tag, " flag after edge"}, 32'(flags_o[i]), 32'(exp_f));
    check(en ? {tag, " irq"} : "R8 irq masked", 32'(irq_o[i]), 32'(exp_irq));
    pin_i[i] = ~pin_i[i];
    cyc(4);
    exp_f2 = exp_f | model_fires(code, !is_fall);
    check({tag, " flag sticky after reversal"}, 32'(flags_o[i]), 32'(exp_f2));
    if (exp_f2) begin
      @(negedge clk); ack_i[i] = 1'b1;
      @(negedge clk); ack_i[i] = 1'b0;
      check("R10 ack clears flag", 32'(flags_o[i]), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1
    check("R1 ctrl reset", 32'(ctrl_rdata), 32'd0);
    check("R1 pol reset", 32'(pol_o), 32'd0);
    check("R1 en reset", 32'(en_o), 32'd0);
    check("R1 flags reset", 32'(flags_o), 32'd0);
    check("R1 irq reset", 32'(irq_o), 32'd0);

    // R2: every control value reads back; sleep bits leave a falling-edge setup intact
    for (int v = 0; v < 256; v++) begin
      wr_ctrl(8'(v));
      check("R2 ctrl readback", 32'(ctrl_rdata), 32'(v));
    end
    wr_ctrl(8'hF2);
    wr_en(3'b001);
    w1c(3'b111);
    pin_i[0] = 1'b0;
    cyc(4);
    check("R2 sleep bits no effect", 32'(irq_o[0]), 32'd1);
    pin_i = 3'b111;
    cyc(4);

    for (int i = 0; i < 3; i++)
      for (int c = (i == 2 ? 2 : 0); c < 4; c++)
        for (int e = 0; e < 2; e++)
          for (int f = 0; f < 2; f++)
            run_case(i, 2'(c), e[0], f[0]);

    // R9: partial write-one-to-clear
    pin_i = 3'b111;
    wr_ctrl(8'h0A);
    wr_pol(1'b0);
    wr_en(3'b000);
    w1c(3'b111);
    pin_i = 3'b000;
    cyc(4);
    check("R9 all flags set", 32'(flags_o), 32'h7);
    w1c(3'b101);
    check("R9 only written ones cleared", 32'(flags_o), 32'h2);
    w1c(3'b000);
    check("R9 zero write keeps flags", 32'(flags_o), 32'h2);
    w1c(3'b010);
    check("R9 last flag cleared", 32'(flags_o), 32'h0);

    // R11: clear held during the set cycle
    pin_i = 3'b111;
    cyc(4);
    w1c(3'b111);
    pin_i[0] = 1'b0;
    cyc(2);
    flag_clr_we = 1'b1; flag_clr_wdata = 3'b001;
    cyc(1);
    flag_clr_we = 1'b0; flag_clr_wdata = '0;
    check("R11 set wins over clear", 32'(flags_o[0]), 32'd1);

    done = 1'b1;
    report();
  end

endmodule